// File: doc/BRIEF.md
# Two-Step Flash Converter Digital Back-End

This block is the clocked logic that sits behind the comparator banks of a 10-bit two-step flash converter. Each clock it takes a 15-wide coarse thermometer vector and a 67-wide fine thermometer vector and removes isolated bubbles from both. It turns the coarse vector into a segment number and the fine vector into a signed offset inside that segment. An adder joins the two and corrects the overlap between neighbouring segments. The sum is clamped into the 10-bit code range, and an out-of-range flag is raised when the sum passes the top code.

Results leave through a pair of registers in series. A conversion sampled at one rising edge is therefore visible on the outputs after the following rising edge. A power-down input freezes both registers, so the code, the flag and the channel tag stay as they were. A 2-bit input-select register is loaded from an address bus while an active-low write strobe is low. Every result carries the select value that was in force when its sample was taken. Samples from the previous input therefore drain out ahead of those from the new one.

Top module: `adc_backend`

## Requirements
- R1: The coarse level is k+1, where k is the highest coarse bit that is set and whose next lower bit is also set (bit 0 needs no lower neighbour). The level is 0 when no bit qualifies, so a bubble below the top or an isolated high bit does not move it.
- R2: The fine level (0 to 67) follows the same bubble rule over the 67 fine bits. Fine bit j stands for an offset of j-2 from the segment base.
- R3: The raw value is 64 × coarse level + fine level − 3. When it lies in 0..1023, `code_out` equals it.
- R4: A raw value below 0 gives `code_out` = 0 with `ovf_out` = 0.
- R5: A raw value of 1024 or more gives `code_out` = 1023 with `ovf_out` = 1. In every other case `ovf_out` = 0.
- R6: Inputs present at rising edge k are reflected on `code_out`, `ovf_out` and `code_chan` after rising edge k+1, provided `pwr_down` is low at both edges.
- R7: At an edge where `pwr_down` is 1, neither register stage loads. The outputs keep their values and the held stage-one result is the first to emerge after release.
- R8: At an edge where `wr_n` is 0, `chan_sel` takes `chan_addr`. Codes 0, 1, 2 and 3 select inputs 1, 2, 3 and 4.
- R9: At an edge where `wr_n` is 1, `chan_sel` is unchanged whatever `chan_addr` holds.
- R10: `code_chan` is the `chan_sel` value that held just before the edge that sampled the result. Results sampled before a select write therefore leave with the old value.
- R11: A synchronous active-high `rst` clears both stages (code, flag, tag) and sets `chan_sel` to 0 (input 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge ends the sample |
| rst | input | 1 | Synchronous reset, active high |
| coarse_therm | input | 15 | Coarse comparator thermometer |
| fine_therm | input | 67 | Fine comparator thermometer, bit j = offset j-2 |
| pwr_down | input | 1 | Freeze output pipeline when high |
| wr_n | input | 1 | Select write strobe, active low |
| chan_addr | input | 2 | Select address |
| chan_sel | output | 2 | Current input select (0..3 = input 1..4) |
| code_out | output | 10 | Converted code |
| ovf_out | output | 1 | Out-of-range flag |
| code_chan | output | 2 | Select value the shown code was sampled with |

## Verification
Power-down and a select write can land on the same edge. The write still lands, but the frozen pipeline keeps the old tag on the outputs. The bench drives both in one cycle and also changes the thermometer inputs while the freeze is on. A behavioural model, which updates its select and its two result slots independently, predicts that the outputs hold. It also predicts that the first code to appear after release is the one held in stage one, carrying the pre-write tag. Overflow and the bubble filter also coincide: near the top of the range, thermometers with stray high bits are applied, and the model judges whether the clamp and the flag still follow the filtered levels.

// File: rtl/adc_be_pkg.sv
package adc_be_pkg;
    localparam int unsigned CODE_W = 10;
    localparam int unsigned SEL_W  = 2;

    typedef struct packed {
        logic [SEL_W-1:0]  chan;
        logic              ovf;
        logic [CODE_W-1:0] code;
    } adc_word_t;
endpackage

// File: rtl/therm_level.sv
// Bubble-tolerant thermometer to level encoder.
module therm_level #(
    parameter int unsigned N  = 15,
    parameter int unsigned LW = $clog2(N + 1)
) (
    input  logic [N-1:0]  therm,
    output logic [LW-1:0] level
);
    logic [N-1:0] qual;

    // A bit qualifies only if its lower neighbour agrees.
    generate
        for (genvar j = 0; j < N; j++) begin : g_qual
            if (j == 0) begin : g_base
                assign qual[j] = therm[j];
            end else begin : g_upper
                assign qual[j] = therm[j] & therm[j-1];
            end
        end
    endgenerate

    always_comb begin
        level = '0;
        for (int j = 0; j < N; j++) begin
            if (qual[j]) level = LW'(j + 1);
        end
    end
endmodule

// File: rtl/seg_merge.sv
// Correcting adder: segment base plus signed fine offset, then clamp.
module seg_merge #(
    parameter int unsigned CODE_W     = 10,
    parameter int unsigned CL_W       = 4,
    parameter int unsigned FL_W       = 7,
    parameter int unsigned STEP_W     = 6,
    parameter int unsigned FINE_UNDER = 2
) (
    input  logic [CL_W-1:0]   coarse_lvl,
    input  logic [FL_W-1:0]   fine_lvl,
    output logic [CODE_W-1:0] code,
    output logic              ovf
);
    localparam int unsigned SW = CODE_W + 3;
    localparam logic signed [SW-1:0] MAX_S = SW'((1 << CODE_W) - 1);
    localparam logic signed [SW-1:0] BIAS  = SW'(FINE_UNDER + 1);

    logic signed [SW-1:0] base_s;
    logic signed [SW-1:0] fine_s;
    logic signed [SW-1:0] sum;

    always_comb begin
        base_s = $signed(SW'(coarse_lvl) << STEP_W);
        fine_s = $signed(SW'(fine_lvl));
        sum    = base_s + fine_s - BIAS;
        if (sum[SW-1]) begin
            code = '0;
            ovf  = 1'b0;
        end else if (sum > MAX_S) begin
            code = '1;
            ovf  = 1'b1;
        end else begin
            code = sum[CODE_W-1:0];
            ovf  = 1'b0;
        end
    end
endmodule

// File: rtl/out_pipe.sv
// Series register chain with common hold.
module out_pipe #(
    parameter int unsigned W      = 13,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else if (!hold) begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/chan_latch.sv
// Input-select register loaded by an active-low strobe.
module chan_latch #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_n,
    input  logic [SEL_W-1:0] addr,
    output logic [SEL_W-1:0] sel
);
    always_ff @(posedge clk) begin
        if (rst)        sel <= '0;
        else if (!wr_n) sel <= addr;
    end
endmodule

// File: rtl/adc_backend.sv
module adc_backend
    import adc_be_pkg::*;
#(
    parameter int unsigned COARSE_N   = 15,
    parameter int unsigned FINE_UNDER = 2,
    parameter int unsigned PIPE_DEPTH = 2,
    parameter int unsigned FINE_N     = (1 << (CODE_W - $clog2(COARSE_N + 1))) + FINE_UNDER + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [COARSE_N-1:0] coarse_therm,
    input  logic [FINE_N-1:0]   fine_therm,
    input  logic                pwr_down,
    input  logic                wr_n,
    input  logic [SEL_W-1:0]    chan_addr,
    output logic [SEL_W-1:0]    chan_sel,
    output logic [CODE_W-1:0]   code_out,
    output logic                ovf_out,
    output logic [SEL_W-1:0]    code_chan
);
    localparam int unsigned CL_W   = $clog2(COARSE_N + 1);
    localparam int unsigned FL_W   = $clog2(FINE_N + 1);
    localparam int unsigned STEP_W = CODE_W - CL_W;
    localparam int unsigned WORD_W = $bits(adc_word_t);

    logic [CL_W-1:0]   c_lvl;
    logic [FL_W-1:0]   f_lvl;
    logic [CODE_W-1:0] m_code;
    logic              m_ovf;
    adc_word_t         w_in;
    adc_word_t         w_out;
    logic [WORD_W-1:0] w_q;

    therm_level #(.N(COARSE_N), .LW(CL_W)) u_coarse (
        .therm (coarse_therm),
        .level (c_lvl)
    );

    therm_level #(.N(FINE_N), .LW(FL_W)) u_fine (
        .therm (fine_therm),
        .level (f_lvl)
    );

    seg_merge #(
        .CODE_W     (CODE_W),
        .CL_W       (CL_W),
        .FL_W       (FL_W),
        .STEP_W     (STEP_W),
        .FINE_UNDER (FINE_UNDER)
    ) u_merge (
        .coarse_lvl (c_lvl),
        .fine_lvl   (f_lvl),
        .code       (m_code),
        .ovf        (m_ovf)
    );

    chan_latch #(.SEL_W(SEL_W)) u_sel (
        .clk  (clk),
        .rst  (rst),
        .wr_n (wr_n),
        .addr (chan_addr),
        .sel  (chan_sel)
    );

    always_comb begin
        w_in.chan = chan_sel;
        w_in.ovf  = m_ovf;
        w_in.code = m_code;
    end

    out_pipe #(.W(WORD_W), .STAGES(PIPE_DEPTH)) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .hold (pwr_down),
        .d    (w_in),
        .q    (w_q)
    );

    assign w_out     = adc_word_t'(w_q);
    assign code_out  = w_out.code;
    assign ovf_out   = w_out.ovf;
    assign code_chan = w_out.chan;
endmodule

// File: rtl/adc_backend_chk.sv
module adc_backend_chk #(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned SEL_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_down,
    input logic              wr_n,
    input logic [SEL_W-1:0]  chan_addr,
    input logic [SEL_W-1:0]  chan_sel,
    input logic [CODE_W-1:0] code_out,
    input logic              ovf_out,
    input logic [SEL_W-1:0]  code_chan
);
    // R5: the flag only ever accompanies the all-ones code
    p_ovf_full_r5: assert property (@(posedge clk) disable iff (rst)
        ovf_out |-> (&code_out));

    // R7: a frozen edge leaves every output alone
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> ($stable(code_out) && $stable(ovf_out) && $stable(code_chan)));

    // R8: strobe low loads the address
    p_sel_load_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> (chan_sel == $past(chan_addr)));

    // R9: strobe high keeps the select
    p_sel_keep_r9: assert property (@(posedge clk) disable iff (rst)
        wr_n |=> $stable(chan_sel));

    // R11: reset clears outputs and select
    p_reset_r11: assert property (@(posedge clk)
        rst |=> (code_out == '0 && !ovf_out && chan_sel == '0 && code_chan == '0));
endmodule

bind adc_backend adc_backend_chk #(.CODE_W(adc_be_pkg::CODE_W), .SEL_W(adc_be_pkg::SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_down  (pwr_down),
    .wr_n      (wr_n),
    .chan_addr (chan_addr),
    .chan_sel  (chan_sel),
    .code_out  (code_out),
    .ovf_out   (ovf_out),
    .code_chan (code_chan)
);

// File: tb/sim_adc_backend.sv
module sim_adc_backend;
    localparam int CLK_PERIOD = 10;
    localparam int CN = 15;
    localparam int FN = 67;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CN-1:0] coarse_therm = '0;
    logic [FN-1:0] fine_therm = '0;
    logic          pwr_down = 1'b0;
    logic          wr_n = 1'b1;
    logic [1:0]    chan_addr = '0;
    logic [1:0]    chan_sel;
    logic [9:0]    code_out;
    logic          ovf_out;
    logic [1:0]    code_chan;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // reference model state
    int m1_code = 0, m1_ovf = 0, m1_tag = 0;
    int m2_code = 0, m2_ovf = 0, m2_tag = 0;
    int m_chan = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_backend u0 (
        .clk          (clk),
        .rst          (rst),
        .coarse_therm (coarse_therm),
        .fine_therm   (fine_therm),
        .pwr_down     (pwr_down),
        .wr_n         (wr_n),
        .chan_addr    (chan_addr),
        .chan_sel     (chan_sel),
        .code_out     (code_out),
        .ovf_out      (ovf_out),
        .code_chan    (code_chan)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [FN-1:0] mk_therm(int n, int lvl, int mode);
        logic [FN-1:0] t = '0;
        for (int j = 0; j < n; j++) if (j < lvl) t[j] = 1'b1;
        if (mode == 1 && lvl >= 4) t[lvl-3] = 1'b0;      // bubble below the top
        if (mode == 2 && lvl + 1 < n) t[lvl+1] = 1'b1;   // stray isolated bit
        return t;
    endfunction

    function automatic int ref_level(logic [FN-1:0] t, int n);
        for (int j = n - 1; j >= 0; j--)
            if (t[j] && (j == 0 || t[j-1])) return j + 1;
        return 0;
    endfunction

    task automatic model_edge();
        int raw;
        if (rst) begin
            m1_code = 0; m1_ovf = 0; m1_tag = 0;
            m2_code = 0; m2_ovf = 0; m2_tag = 0;
            m_chan = 0;
            return;
        end
        if (!pwr_down) begin
            m2_code = m1_code; m2_ovf = m1_ovf; m2_tag = m1_tag;
            raw = 64 * ref_level({{(FN-CN){1'b0}}, coarse_therm}, CN)
                + ref_level(fine_therm, FN) - 3;
            if (raw < 0)          begin m1_code = 0;    m1_ovf = 0; end
            else if (raw > 1023)  begin m1_code = 1023; m1_ovf = 1; end
            else                  begin m1_code = raw;  m1_ovf = 0; end
            m1_tag = m_chan;
        end
        if (!wr_n) m_chan = chan_addr;
    endtask

    // one clock: sample after the edge, compare, return at the falling edge
    task automatic cyc(string req);
        bit was_rst = rst;
        bit was_wr  = !wr_n;
        @(posedge clk);
        #1;
        model_edge();
        if (was_rst) begin
            check("R11", "code", code_out, 0);
            check("R11", "ovf", ovf_out, 0);
            check("R11", "sel", chan_sel, 0);
            check("R11", "tag", code_chan, 0);
        end else begin
            check(req, "code", code_out, m2_code);
            check("R5", "ovf", ovf_out, m2_ovf);
            check(was_wr ? "R8" : "R9", "sel", chan_sel, m_chan);
            check("R10", "tag", code_chan, m2_tag);
        end
        @(negedge clk);
    endtask

    task automatic apply(int cl, int cm, int fl, int fm);
        coarse_therm = mk_therm(CN, cl, cm)[CN-1:0];
        fine_therm   = mk_therm(FN, fl, fm);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int fset[7] = '{0, 1, 2, 3, 35, 66, 67};
        @(negedge clk);
        repeat (3) cyc("R11");
        rst = 1'b0;

        // R3 sweep over all segments and offsets, incl. R4 and R5 corners
        for (int c = 0; c <= 15; c++) begin
            for (int k = 0; k < 7; k++) begin
                apply(c, 0, fset[k], 0);
                cyc("R3");
            end
        end
        apply(0, 0, 0, 0); cyc("R4");
        apply(0, 0, 2, 0); cyc("R4");
        apply(15, 0, 67, 0); cyc("R5");
        apply(15, 0, 66, 0); cyc("R5");
        cyc("R6");
        apply(7, 0, 10, 0); cyc("R6");
        apply(8, 0, 50, 0); cyc("R6");
        cyc("R6");

        // R1 coarse bubbles and stray bits, R2 fine likewise
        for (int c = 0; c <= 15; c++) begin
            apply(c, 1, 20, 0); cyc("R1");
            apply(c, 2, 20, 0); cyc("R1");
        end
        for (int f = 0; f <= 67; f += 3) begin
            apply(5, 0, f, 1); cyc("R2");
            apply(15, 2, f, 2); cyc("R2");
        end

        // R8 / R9 select writes and ignored addresses, R10 tags
        for (int a = 0; a < 4; a++) begin
            wr_n = 1'b0; chan_addr = 2'(a); apply(a + 3, 0, 30, 0);
            cyc("R10");
            wr_n = 1'b1; chan_addr = 2'(3 - a);
            cyc("R9");
            cyc("R10");
        end

        // R7 freeze while inputs and select change
        apply(9, 0, 40, 0); cyc("R7");
        pwr_down = 1'b1;
        wr_n = 1'b0; chan_addr = 2'd1; apply(2, 0, 5, 0);
        cyc("R7");
        wr_n = 1'b1; apply(14, 0, 60, 0);
        repeat (3) cyc("R7");
        pwr_down = 1'b0;
        apply(1, 0, 9, 0);
        cyc("R7");
        cyc("R7");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            apply(int'($urandom_range(15)), int'($urandom_range(2)),
                  int'($urandom_range(67)), int'($urandom_range(2)));
            pwr_down  = ($urandom_range(7) == 0);
            wr_n      = ($urandom_range(3) != 0);
            chan_addr = 2'($urandom_range(3));
            cyc("R6");
        end

        // reset in mid-run
        rst = 1'b1; cyc("R11");
        rst = 1'b0; pwr_down = 1'b0; wr_n = 1'b1;
        apply(4, 0, 4, 0); cyc("R3");
        cyc("R3");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule